// File: doc/BRIEF.md
# Bus Activity Monitor Channel

This block watches one stream of bus events and turns it into interrupts that a power-management routine can act on. Every cycle in which the event strobe is high adds a programmable weight to a period accumulator. A millisecond tick marks time, and after a programmable number of ticks the accumulated count is closed off as one sample. Each sample updates a running exponential average, whose window is a power of two set in the control word.

Each sample is compared against a raw upper and lower limit. Runs of consecutive breaches in either direction are counted, and a status flag is raised once a run reaches the programmed length. The new average is compared against its own upper and lower limits and flags a breach at once. Status flags are cleared by writing ones to them. The interrupt output is a level that stays high while any enabled flag is set. The sample period length comes in on a port from a period register shared with other channels.

Top module: `actmon_channel`

## Requirements
- R1: After reset the control word, all watermarks and the average read 0, the count weight reads 0x400, the status word reads 0 and `irq` is low.
- R2: While running, each cycle with `evt_strobe` high adds the count weight to the period count, saturating at 0xFFFFFFFF. A period closes on the `ms_tick` that arrives when `period_len_m1 + 1` ticks have been seen. An event in the closing cycle belongs to the next period.
- R3: At each period close the average becomes avg + ((count - avg) >>> (K+1)), using an arithmetic shift that rounds toward minus infinity. K is held in control bits 12:10, so the window is 2^(K+1) samples.
- R4: A write to offset 0x0C loads the average directly. Offset 0x20 reads the current average, and writes to 0x20 are ignored.
- R5: A period whose count exceeds the raw upper limit (offset 0x04) extends the above-run. A period that does not exceed it resets the run to zero. When the run reaches (control bits 28:26) + 1, status bit 31 sets and the run restarts from zero.
- R6: A period whose count is below the raw lower limit (offset 0x08) extends the below-run. A period that is not below it resets the run. When the run reaches (control bits 25:23) + 1, status bit 30 sets and the run restarts.
- R7: At period close, status bit 29 sets when the new average exceeds the average upper limit (offset 0x10). Status bit 28 sets when the new average is below the average lower limit (offset 0x14).
- R8: Writing to status (offset 0x24) clears exactly the bits written as one. A flag set in the same cycle wins over the clear.
- R9: `irq` is high when an enabled status bit is set. The enables are control bit 30 for status 31, bit 29 for status 30, bit 21 for status 29 and bit 20 for status 28.
- R10: The channel runs only when control bit 31 (enable) and bit 18 (periodic sampling) are both set. Otherwise nothing accumulates, no period closes, the run counters are zero, and the average and the status hold.
- R11: Control (0x00), the watermarks and the weight (0x18) read back as written. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_strobe | input | 1 | One bus event in this cycle |
| ms_tick | input | 1 | Single-cycle millisecond marker |
| period_len_m1 | input | PERIOD_W | Sample period in ticks, minus one |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a sequence of periods whose average falls through negative differences. A design that truncated toward zero instead of rounding down would end one count high, and the error would then carry into later samples. Breach runs are broken on purpose one period short of their length. A counter that never reset would raise the below flag where none is expected. Tests also cover a status clear that lands in the same cycle as a new flag, a period that spans several ticks, and a channel with either run bit clear. Each of these catches a design that loses a flag, closes a period early, or keeps sampling while stopped.

// File: rtl/actmon_pkg.sv
package actmon_pkg;

  localparam int ACT_W  = 32;
  localparam int K_W    = 3;
  localparam int CONS_W = 3;
  localparam int ADDR_W = 6;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_RAW_HI   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_RAW_LO   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_AVG_INIT = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_AVG_HI   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_AVG_LO   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_WEIGHT   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_AVG_CUR  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 6'h24;

  // control word fields
  localparam int C_RUN_EN   = 31;
  localparam int C_UP_IE    = 30;
  localparam int C_DN_IE    = 29;
  localparam int C_UP_NUM   = 26;
  localparam int C_DN_NUM   = 23;
  localparam int C_AVG_HIE  = 21;
  localparam int C_AVG_LIE  = 20;
  localparam int C_PERIODIC = 18;
  localparam int C_K_LSB    = 10;

  // status flags, index = bit - 28
  localparam int S_BASE   = 28;
  localparam int S_AVG_LO = 0;
  localparam int S_AVG_HI = 1;
  localparam int S_DN     = 2;
  localparam int S_UP     = 3;
  localparam int S_N      = 4;

  localparam logic [ACT_W-1:0] WEIGHT_RST = 32'h0000_0400;

  function automatic logic ctrl_bit(input logic [ACT_W-1:0] ctrl, input int pos);
    return ctrl[pos];
  endfunction

  function automatic logic [K_W-1:0] ctrl_k(input logic [ACT_W-1:0] ctrl);
    return ctrl[C_K_LSB +: K_W];
  endfunction

  function automatic logic [CONS_W-1:0] ctrl_num(input logic [ACT_W-1:0] ctrl, input int lsb);
    return ctrl[lsb +: CONS_W];
  endfunction

  // saturating accumulate
  function automatic logic [ACT_W-1:0] sat_add(input logic [ACT_W-1:0] a,
                                               input logic [ACT_W-1:0] b);
    logic [ACT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACT_W] ? {ACT_W{1'b1}} : s[ACT_W-1:0];
  endfunction

  // one step of the exponential filter, rounding toward minus infinity
  function automatic logic [ACT_W-1:0] avg_step(input logic [ACT_W-1:0] avg,
                                                input logic [ACT_W-1:0] smp,
                                                input logic [K_W-1:0]   k);
    logic signed [ACT_W+1:0] d;
    d = $signed({2'b00, smp}) - $signed({2'b00, avg});
    d = d >>> (int'(k) + 1);
    return avg + d[ACT_W-1:0];
  endfunction

endpackage

// File: rtl/actmon_sampler.sv
module actmon_sampler
  import actmon_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                evt,
  input  logic                ms_tick,
  input  logic [PERIOD_W-1:0] period_m1,
  input  logic [ACT_W-1:0]    weight,
  output logic                period_end,
  output logic [ACT_W-1:0]    acc_q
);

  logic [PERIOD_W-1:0] tick_cnt_q;

  assign period_end = run && ms_tick && (tick_cnt_q == period_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt_q <= '0;
    end else if (!run) begin
      tick_cnt_q <= '0;
    end else if (period_end) begin
      tick_cnt_q <= '0;
    end else if (ms_tick) begin
      tick_cnt_q <= tick_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (!run) begin
      acc_q <= '0;
    end else if (period_end) begin
      acc_q <= evt ? weight : '0;
    end else if (evt) begin
      acc_q <= sat_add(acc_q, weight);
    end
  end

endmodule

// File: rtl/actmon_avg.sv
module actmon_avg
  import actmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_end,
  input  logic [ACT_W-1:0] sample,
  input  logic [K_W-1:0]   k,
  input  logic             ld,
  input  logic [ACT_W-1:0] ld_val,
  output logic [ACT_W-1:0] avg_q,
  output logic [ACT_W-1:0] avg_next
);

  assign avg_next = avg_step(avg_q, sample, k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q <= '0;
    end else if (ld) begin
      avg_q <= ld_val;
    end else if (period_end) begin
      avg_q <= avg_next;
    end
  end

endmodule

// File: rtl/actmon_breach.sv
module actmon_breach
  import actmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              period_end,
  input  logic              hit,
  input  logic [CONS_W-1:0] num,
  output logic [CONS_W-1:0] cnt_q,
  output logic              fire
);

  assign fire = period_end && hit && (cnt_q == num);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (period_end) begin
      if (!hit || fire) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/actmon_regs.sv
module actmon_regs
  import actmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ACT_W-1:0]  wdata,
  input  logic [ACT_W-1:0]  avg_q,
  input  logic [S_N-1:0]    set_vec,
  output logic [ACT_W-1:0]  ctrl_q,
  output logic [ACT_W-1:0]  raw_hi_q,
  output logic [ACT_W-1:0]  raw_lo_q,
  output logic [ACT_W-1:0]  avg_hi_q,
  output logic [ACT_W-1:0]  avg_lo_q,
  output logic [ACT_W-1:0]  weight_q,
  output logic [S_N-1:0]    status_q,
  output logic              avg_ld,
  output logic              st_wr,
  output logic [ACT_W-1:0]  rdata
);

  logic [S_N-1:0] clr_vec;

  assign avg_ld  = wr_en && (addr == OFS_AVG_INIT);
  assign st_wr   = wr_en && (addr == OFS_STATUS);
  assign clr_vec = st_wr ? wdata[S_BASE +: S_N] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      raw_hi_q <= '0;
      raw_lo_q <= '0;
      avg_hi_q <= '0;
      avg_lo_q <= '0;
      weight_q <= WEIGHT_RST;
    end else if (wr_en) begin
      case (addr)
        OFS_CTRL:   ctrl_q   <= wdata;
        OFS_RAW_HI: raw_hi_q <= wdata;
        OFS_RAW_LO: raw_lo_q <= wdata;
        OFS_AVG_HI: avg_hi_q <= wdata;
        OFS_AVG_LO: avg_lo_q <= wdata;
        OFS_WEIGHT: weight_q <= wdata;
        default: ;
      endcase
    end
  end

  // new flags take priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  always_comb begin
    case (addr)
      OFS_CTRL:    rdata = ctrl_q;
      OFS_RAW_HI:  rdata = raw_hi_q;
      OFS_RAW_LO:  rdata = raw_lo_q;
      OFS_AVG_HI:  rdata = avg_hi_q;
      OFS_AVG_LO:  rdata = avg_lo_q;
      OFS_WEIGHT:  rdata = weight_q;
      OFS_AVG_CUR: rdata = avg_q;
      OFS_STATUS:  rdata = {status_q, {S_BASE{1'b0}}};
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/actmon_channel.sv
module actmon_channel
  import actmon_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_strobe,
  input  logic                ms_tick,
  input  logic [PERIOD_W-1:0] period_len_m1,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [ACT_W-1:0]    reg_wdata,
  output logic [ACT_W-1:0]    reg_rdata,
  output logic                irq
);

  logic [ACT_W-1:0]  ctrl_q, raw_hi_q, raw_lo_q, avg_hi_q, avg_lo_q, weight_q;
  logic [S_N-1:0]    status_q, set_vec, irq_en;
  logic              avg_ld, st_wr, run, period_end;
  logic [ACT_W-1:0]  acc_q, avg_q, avg_next;
  logic              up_hit, dn_hit, up_fire, dn_fire;
  logic [CONS_W-1:0] up_cnt, dn_cnt;

  actmon_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .avg_q    (avg_q),
    .set_vec  (set_vec),
    .ctrl_q   (ctrl_q),
    .raw_hi_q (raw_hi_q),
    .raw_lo_q (raw_lo_q),
    .avg_hi_q (avg_hi_q),
    .avg_lo_q (avg_lo_q),
    .weight_q (weight_q),
    .status_q (status_q),
    .avg_ld   (avg_ld),
    .st_wr    (st_wr),
    .rdata    (reg_rdata)
  );

  assign run = ctrl_bit(ctrl_q, C_RUN_EN) && ctrl_bit(ctrl_q, C_PERIODIC);

  actmon_sampler #(.PERIOD_W(PERIOD_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .evt        (evt_strobe),
    .ms_tick    (ms_tick),
    .period_m1  (period_len_m1),
    .weight     (weight_q),
    .period_end (period_end),
    .acc_q      (acc_q)
  );

  actmon_avg u_avg (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_end (period_end),
    .sample     (acc_q),
    .k          (ctrl_k(ctrl_q)),
    .ld         (avg_ld),
    .ld_val     (reg_wdata),
    .avg_q      (avg_q),
    .avg_next   (avg_next)
  );

  assign up_hit = acc_q > raw_hi_q;
  assign dn_hit = acc_q < raw_lo_q;

  actmon_breach u_up (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .period_end (period_end),
    .hit        (up_hit),
    .num        (ctrl_num(ctrl_q, C_UP_NUM)),
    .cnt_q      (up_cnt),
    .fire       (up_fire)
  );

  actmon_breach u_dn (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .period_end (period_end),
    .hit        (dn_hit),
    .num        (ctrl_num(ctrl_q, C_DN_NUM)),
    .cnt_q      (dn_cnt),
    .fire       (dn_fire)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[S_UP]     = up_fire;
    set_vec[S_DN]     = dn_fire;
    set_vec[S_AVG_HI] = period_end && (avg_next > avg_hi_q);
    set_vec[S_AVG_LO] = period_end && (avg_next < avg_lo_q);
  end

  always_comb begin
    irq_en           = '0;
    irq_en[S_UP]     = ctrl_bit(ctrl_q, C_UP_IE);
    irq_en[S_DN]     = ctrl_bit(ctrl_q, C_DN_IE);
    irq_en[S_AVG_HI] = ctrl_bit(ctrl_q, C_AVG_HIE);
    irq_en[S_AVG_LO] = ctrl_bit(ctrl_q, C_AVG_LIE);
  end

  assign irq = |(status_q & irq_en);

endmodule

// File: rtl/actmon_channel_chk.sv
module actmon_channel_chk
  import actmon_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              period_end,
  input logic              avg_ld,
  input logic              st_wr,
  input logic              evt_strobe,
  input logic              up_fire,
  input logic              dn_fire,
  input logic [ACT_W-1:0]  acc_q,
  input logic [ACT_W-1:0]  avg_q,
  input logic [S_N-1:0]    status_q,
  input logic [CONS_W-1:0] up_cnt,
  input logic [CONS_W-1:0] dn_cnt,
  input logic              irq
);

  // R3: the average moves only at a period close or an initial load
  assert_avg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !avg_ld) |=> $stable(avg_q));

  // R2: a close with no event in that cycle leaves an empty count
  assert_acc_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !evt_strobe) |=> (acc_q == '0));

  // R5: the above flag rises only after an above-run completes
  assert_up_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[S_UP]) |-> $past(up_fire));

  // R6: the below flag rises only after a below-run completes
  assert_dn_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[S_DN]) |-> $past(dn_fire));

  // R9: no flag set means no interrupt
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq);

  // R10: a stopped channel holds its status and zeroes its runs
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !st_wr) |=> ($stable(status_q) && up_cnt == '0 && dn_cnt == '0));

endmodule

bind actmon_channel actmon_channel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .period_end (period_end),
  .avg_ld     (avg_ld),
  .st_wr      (st_wr),
  .evt_strobe (evt_strobe),
  .up_fire    (up_fire),
  .dn_fire    (dn_fire),
  .acc_q      (acc_q),
  .avg_q      (avg_q),
  .status_q   (status_q),
  .up_cnt     (up_cnt),
  .dn_cnt     (dn_cnt),
  .irq        (irq)
);

// File: tb/actmon_channel_test.sv
module actmon_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_strobe = 1'b0;
  logic        ms_tick = 1'b0;
  logic [7:0]  period_len_m1 = 8'd0;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_addr = 6'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  actmon_channel #(.PERIOD_W(8)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_strobe    (evt_strobe),
    .ms_tick       (ms_tick),
    .period_len_m1 (period_len_m1),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq           (irq)
  );

  // weight 4, K=0, raw limits 20/8, average limits 16/4,
  // above run length 2, below run length 3, average starts at 0
  localparam int NV = 11;
  localparam logic [7:0]  V_N   [NV] = '{8'd6, 8'd6, 8'd1, 8'd0, 8'd1, 8'd0,
                                         8'd3, 8'd0, 8'd0, 8'd6, 8'd0};
  localparam logic [31:0] V_AVG [NV] = '{32'd12, 32'd18, 32'd11, 32'd5, 32'd4, 32'd2,
                                         32'd7, 32'd3, 32'd1, 32'd12, 32'd6};
  localparam logic [31:0] V_ST  [NV] = '{32'h0, 32'hA000_0000, 32'h0, 32'h0,
                                         32'h4000_0000, 32'h1000_0000, 32'h0,
                                         32'h1000_0000, 32'h1000_0000, 32'h0, 32'h0};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // n event cycles, then one closing tick with no event
  task automatic run_period(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      evt_strobe = 1'b1;
    end
    @(negedge clk);
    evt_strobe = 1'b0;
    ms_tick    = 1'b1;
    @(negedge clk);
    ms_tick    = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, v); check("R1 ctrl", v, 32'h0);
    rd(6'h18, v); check("R1 weight", v, 32'h400);
    rd(6'h24, v); check("R1 status", v, 32'h0);
    rd(6'h20, v); check("R1 avg", v, 32'h0);
    rd(6'h04, v); check("R1 raw_hi", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    wr(6'h04, 32'd20);
    wr(6'h08, 32'd8);
    wr(6'h10, 32'd16);
    wr(6'h14, 32'd4);
    wr(6'h18, 32'd4);
    wr(6'h0C, 32'd0);
    wr(6'h00, 32'hC504_0000);

    // R2 R3 R5 R6 R7 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      run_period(int'(V_N[i]));
      rd(6'h20, v); check($sformatf("R3 avg vec%0d", i), v, V_AVG[i]);
      rd(6'h24, v); check($sformatf("R5/R6/R7 status vec%0d", i), v, V_ST[i]);
      check($sformatf("R9 irq vec%0d", i), {31'b0, irq}, {31'b0, V_ST[i][31]});
      if (i == 1) begin
        wr(6'h24, 32'h8000_0000);
        rd(6'h24, v); check("R8 partial clear", v, 32'h2000_0000);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);
      end
      wr(6'h24, 32'hFFFF_FFFF);
    end

    // R4 write to the average readout is ignored, initial load works
    wr(6'h20, 32'h0000_FFFF);
    rd(6'h20, v); check("R4 ignored write", v, 32'd6);
    wr(6'h0C, 32'd100);
    rd(6'h20, v); check("R4 init load", v, 32'd100);

    // R2 period of three ticks
    period_len_m1 = 8'd2;
    run_period(10);
    rd(6'h20, v); check("R2 tick1 hold", v, 32'd100);
    run_period(0);
    rd(6'h20, v); check("R2 tick2 hold", v, 32'd100);
    run_period(0);
    rd(6'h20, v); check("R2 tick3 close", v, 32'd70);
    rd(6'h24, v); check("R7 avg above", v, 32'h2000_0000);
    check("R9 masked flag", {31'b0, irq}, 32'h0);
    wr(6'h00, 32'hC524_0000);
    check("R9 avg above enabled", {31'b0, irq}, 32'h1);
    wr(6'h24, 32'hFFFF_FFFF);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
    period_len_m1 = 8'd0;

    // R3 K=2 window of 8; above run continues from the previous period
    wr(6'h00, 32'hC504_0800);
    wr(6'h0C, 32'd0);
    run_period(20);
    rd(6'h20, v); check("R3 K=2 step", v, 32'd10);
    rd(6'h24, v); check("R5 run completes", v, 32'h8000_0000);
    wr(6'h24, 32'hFFFF_FFFF);

    // R10 enable clear, then periodic clear
    wr(6'h00, 32'h4504_0000);
    run_period(5);
    rd(6'h20, v); check("R10 disabled avg", v, 32'd10);
    rd(6'h24, v); check("R10 disabled status", v, 32'h0);
    wr(6'h00, 32'hC500_0000);
    run_period(5);
    rd(6'h20, v); check("R10 no periodic avg", v, 32'd10);

    // R2 weight 3
    wr(6'h00, 32'hC504_0000);
    wr(6'h18, 32'd3);
    wr(6'h0C, 32'd0);
    run_period(4);
    rd(6'h20, v); check("R2 weight 3", v, 32'd6);
    rd(6'h24, v); check("R2 no flags", v, 32'h0);

    // R11 readback
    rd(6'h04, v); check("R11 raw_hi", v, 32'd20);
    rd(6'h18, v); check("R11 weight", v, 32'd3);
    rd(6'h1C, v); check("R11 unmapped", v, 32'h0);
    rd(6'h00, v); check("R11 ctrl", v, 32'hC504_0000);

    // R8 set wins over a clear in the same cycle (avg 6 -> 3 < 4)
    @(negedge clk);
    ms_tick   = 1'b1;
    reg_wr_en = 1'b1;
    reg_addr  = 6'h24;
    reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    ms_tick   = 1'b0;
    reg_wr_en = 1'b0;
    rd(6'h24, v); check("R8 set beats clear", v, 32'h1000_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule